// File: doc/BRIEF.md
# DRAM Power-Down Sequencer

This block sits on the controller side of a DDR3-class memory channel. It decides when the memory may be placed in power-down, and it drives the clock-enable line low and high. While the line falls it forces the command slot to NOP/Deselect. After wakeup it holds commands back until the exit delays are met. When the controller requests power-down, entry waits until three things hold: no blocking operation is running, the bank state is known, and the idle counter has reached its threshold. Once the clock enable is low, the block records whether the part is in active power-down (a bank is open) or precharge power-down (all banks closed). At entry it also latches the slow/fast exit-mode bit.

On exit there are two grant outputs. One covers commands that do not need the DLL, such as activate, refresh, mode register writes and precharges. The other covers commands that do need it, such as reads and ODT control. After precharge power-down with slow exit selected, the second grant waits the longer DLL relock delay. In every other case both grants open together. A low period is never allowed to exceed nine refresh intervals: the block raises a wakeup pulse and lifts the clock enable itself. All delays are parameters counted in clock cycles.

Top module: `pdn_seq`

## Requirements
- R1: In the normal state, an entry request with no blocking operation drives `cke` low at the next clock edge, provided `idle_cnt` is at least IDLE_MIN. `force_nop` is high in the first low cycle and for the T_CPDED cycles after it. Both grants are low while `cke` is low.
- R2: Any set bit of `busy_block` prevents entry. The bits are: bit 0 mode register set, bit 1 MPR access, bit 2 ZQ calibration, bit 3 DLL lock, bit 4 read/write burst. A request seen while entry is blocked is kept pending, and entry happens once the bits clear, without a new request.
- R3: Set bits in `busy_allow` do not prevent entry. The bits are: bit 0 activate, bit 1 precharge, bit 2 auto-precharge, bit 3 refresh.
- R4: While `cke` is low, `pd_active_mode` shows the OR of `bank_open`. It is sampled each low cycle (starting with the entry edge) until the first cycle in which `busy_allow` is zero, and is frozen from then on. It is 0 while `cke` is high.
- R5: `cke` stays low for at least T_CKE cycles. A wakeup requested earlier is held, and `cke` rises after the first low cycle that meets T_CKE and is past the NOP window.
- R6: `grant_other` is low for the first T_XP cycles with `cke` high and rises in cycle T_XP+1.
- R7: `grant_dll` rises together with `grant_other` after active power-down, or after precharge power-down with `exit_fast` = 1. After precharge power-down with `exit_fast` = 0, it rises in cycle T_XPDLL+1 of `cke` high. `exit_fast` is latched at the entry edge.
- R8: If `cke` has been low for 9·T_REFI cycles, `refresh_wake` pulses for one cycle in that last low cycle and `cke` rises at the next edge.
- R9: Synchronous reset, from any state, sets `cke` high, both grants high and `force_nop` low, and drops any pending request.
- R10: An entry request is not acted on while `idle_cnt` is below IDLE_MIN. It stays pending until the count is high enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| busy_block | input | 5 | Operations that forbid entry |
| busy_allow | input | 4 | Operations that may still complete during entry |
| bank_open | input | N_BANKS | Open/closed flag per bank |
| exit_fast | input | 1 | Exit-mode bit: 1 fast, 0 slow |
| idle_cnt | input | IDLE_W | Idle cycles counted by the scheduler |
| cke | output | 1 | Clock enable to the memory |
| force_nop | output | 1 | Command slot must carry NOP/Deselect |
| grant_other | output | 1 | Commands not needing the DLL may issue |
| grant_dll | output | 1 | DLL-dependent commands may issue |
| pd_active_mode | output | 1 | 1 = active power-down, 0 = precharge power-down |
| refresh_wake | output | 1 | Forced wakeup because the refresh limit was reached |

## Verification
Most internal faults show up at the ports within a few cycles.

- A wrong low-phase count moves the `force_nop` window or the `cke` rise by one cycle or more. The bench compares every cycle of an entry/exit sequence, so such a shift is caught on the cycle it occurs.
- A mis-latched exit bit or a wrong bank classification shows up as `grant_dll` rising seven cycles early or late after wakeup.
- A lost pending request shows up as `cke` staying high after the blocking flag clears.
- A broken refresh cap only appears after 72 low cycles with default parameters, so a dedicated run holds power-down until the block ends it by itself.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    localparam int unsigned BLK_OPS = 5;
    localparam int unsigned ALW_OPS = 4;

    typedef enum logic [1:0] {
        PD_UP    = 2'd0,
        PD_ENTER = 2'd1,
        PD_DOWN  = 2'd2,
        PD_EXIT  = 2'd3
    } pd_state_e;

    // bit 0 first: mode register set, MPR, ZQ calibration, DLL lock, rd/wr burst
    typedef struct packed {
        logic rdwr;
        logic dll_lock;
        logic zq_cal;
        logic mpr;
        logic mrs;
    } blk_ops_t;

    // bit 0 first: activate, precharge, auto-precharge, refresh
    typedef struct packed {
        logic refresh;
        logic auto_pre;
        logic precharge;
        logic activate;
    } alw_ops_t;

    function automatic logic st_is_low(pd_state_e s);
        return (s == PD_ENTER) || (s == PD_DOWN);
    endfunction

    function automatic logic needs_long_dll(logic slow, logic active);
        return slow && !active;
    endfunction

endpackage

// File: rtl/pdn_entry_gate.sv
module pdn_entry_gate
    import pdn_pkg::*;
#(
    parameter int unsigned IDLE_W   = 8,
    parameter int unsigned IDLE_MIN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  pd_state_e           st,
    input  logic                pd_req,
    input  logic [BLK_OPS-1:0]  busy_block,
    input  logic [IDLE_W-1:0]   idle_cnt,
    output logic                go_enter
);
    localparam logic [IDLE_W-1:0] IDLE_MIN_L = IDLE_W'(IDLE_MIN);

    blk_ops_t ops;
    logic     pend_q;
    logic     want;
    logic     clear_to_go;

    assign ops         = blk_ops_t'(busy_block);
    assign want        = pend_q || pd_req;
    assign clear_to_go = !(|ops) && (idle_cnt >= IDLE_MIN_L);
    assign go_enter    = (st == PD_UP) && want && clear_to_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (go_enter) begin
            pend_q <= 1'b0;
        end else if (pd_req && (st == PD_UP || st == PD_EXIT)) begin
            pend_q <= 1'b1;
        end
    end

    // R2 / R10: a pending request survives until it is served
    assert_pend_held_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_q && st == PD_UP && !clear_to_go) |=> pend_q);

endmodule

// File: rtl/pdn_low_timer.sv
module pdn_low_timer
    import pdn_pkg::*;
#(
    parameter int unsigned N_BANKS  = 8,
    parameter int unsigned T_CPDED  = 2,
    parameter int unsigned T_CKE    = 4,
    parameter int unsigned T_PD_MAX = 72
) (
    input  logic                clk,
    input  logic                rst,
    input  pd_state_e           st,
    input  logic                go_enter,
    input  logic [N_BANKS-1:0]  bank_open,
    input  logic [ALW_OPS-1:0]  busy_allow,
    input  logic                exit_fast,
    output logic                cpded_done,
    output logic                min_met,
    output logic                cap_hit,
    output logic                class_active,
    output logic                slow_exit
);
    localparam int unsigned    LW       = $clog2(T_PD_MAX + 2);
    localparam logic [LW-1:0]  NOP_END  = LW'(T_CPDED + 1);
    localparam logic [LW-1:0]  CKE_L    = LW'(T_CKE);
    localparam logic [LW-1:0]  CAP_L    = LW'(T_PD_MAX);

    alw_ops_t       alw;
    logic           low;
    logic [LW-1:0]  lowcnt_q;
    logic           settled_q;
    logic           class_q;
    logic           slow_q;

    assign alw = alw_ops_t'(busy_allow);
    assign low = st_is_low(st);

    always_ff @(posedge clk) begin
        if (rst) begin
            lowcnt_q <= '0;
        end else if (go_enter) begin
            lowcnt_q <= LW'(1);
        end else if (low) begin
            lowcnt_q <= lowcnt_q + LW'(1);
        end else begin
            lowcnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            class_q   <= 1'b0;
            settled_q <= 1'b1;
            slow_q    <= 1'b0;
        end else if (go_enter) begin
            class_q   <= |bank_open;
            settled_q <= !(|alw);
            slow_q    <= !exit_fast;
        end else if (low && !settled_q) begin
            class_q   <= |bank_open;
            settled_q <= !(|alw);
        end
    end

    assign cpded_done   = lowcnt_q >= NOP_END;
    assign min_met      = lowcnt_q >= CKE_L;
    assign cap_hit      = lowcnt_q >= CAP_L;
    assign class_active = class_q;
    assign slow_exit    = slow_q;

    // R8: the low phase never outlasts the refresh budget
    assert_cap_bound_R8: assert property (@(posedge clk) disable iff (rst)
        low |-> (lowcnt_q <= CAP_L));

    // R4: classification is frozen once in-flight operations have finished
    assert_class_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (low && settled_q && !go_enter) |=> (!st_is_low(st) || $stable(class_q)));

endmodule

// File: rtl/pdn_exit_timer.sv
module pdn_exit_timer
    import pdn_pkg::*;
#(
    parameter int unsigned T_XP    = 3,
    parameter int unsigned T_XPDLL = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  pd_state_e  st,
    input  logic       class_active,
    input  logic       slow_exit,
    output logic       xp_met,
    output logic       dll_met
);
    localparam int unsigned    XW      = $clog2(T_XPDLL + 2);
    localparam logic [XW-1:0]  XP_L    = XW'(T_XP);
    localparam logic [XW-1:0]  XPDLL_L = XW'(T_XPDLL);

    logic [XW-1:0] xcnt_q;
    logic          long_wait;

    assign long_wait = needs_long_dll(slow_exit, class_active);
    assign xp_met    = xcnt_q >= XP_L;
    assign dll_met   = long_wait ? (xcnt_q >= XPDLL_L) : xp_met;

    always_ff @(posedge clk) begin
        if (rst) begin
            xcnt_q <= '0;
        end else if (st == PD_EXIT && !dll_met) begin
            xcnt_q <= xcnt_q + XW'(1);
        end else begin
            xcnt_q <= '0;
        end
    end

    // R7: DLL-dependent commands never open before the others
    assert_dll_after_xp_R7: assert property (@(posedge clk) disable iff (rst)
        (st == PD_EXIT && dll_met) |-> xp_met);

endmodule

// File: rtl/pdn_seq.sv
module pdn_seq
    import pdn_pkg::*;
#(
    parameter int unsigned N_BANKS  = 8,
    parameter int unsigned IDLE_W   = 8,
    parameter int unsigned IDLE_MIN = 4,
    parameter int unsigned T_CPDED  = 2,
    parameter int unsigned T_CKE    = 4,
    parameter int unsigned T_XP     = 3,
    parameter int unsigned T_XPDLL  = 10,
    parameter int unsigned T_REFI   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pd_req,
    input  logic                wake_req,
    input  logic [4:0]          busy_block,
    input  logic [3:0]          busy_allow,
    input  logic [N_BANKS-1:0]  bank_open,
    input  logic                exit_fast,
    input  logic [IDLE_W-1:0]   idle_cnt,
    output logic                cke,
    output logic                force_nop,
    output logic                grant_other,
    output logic                grant_dll,
    output logic                pd_active_mode,
    output logic                refresh_wake
);
    localparam int unsigned T_PD_MAX = 9 * T_REFI;

    pd_state_e st_q, st_d;
    logic      go_enter, go_exit;
    logic      cpded_done, min_met, cap_hit;
    logic      class_active, slow_exit;
    logic      xp_met, dll_met;
    logic      wake_pend_q;
    logic      low;

    pdn_entry_gate #(
        .IDLE_W   (IDLE_W),
        .IDLE_MIN (IDLE_MIN)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .st         (st_q),
        .pd_req     (pd_req),
        .busy_block (busy_block),
        .idle_cnt   (idle_cnt),
        .go_enter   (go_enter)
    );

    pdn_low_timer #(
        .N_BANKS  (N_BANKS),
        .T_CPDED  (T_CPDED),
        .T_CKE    (T_CKE),
        .T_PD_MAX (T_PD_MAX)
    ) u_low (
        .clk          (clk),
        .rst          (rst),
        .st           (st_q),
        .go_enter     (go_enter),
        .bank_open    (bank_open),
        .busy_allow   (busy_allow),
        .exit_fast    (exit_fast),
        .cpded_done   (cpded_done),
        .min_met      (min_met),
        .cap_hit      (cap_hit),
        .class_active (class_active),
        .slow_exit    (slow_exit)
    );

    pdn_exit_timer #(
        .T_XP    (T_XP),
        .T_XPDLL (T_XPDLL)
    ) u_exit (
        .clk          (clk),
        .rst          (rst),
        .st           (st_q),
        .class_active (class_active),
        .slow_exit    (slow_exit),
        .xp_met       (xp_met),
        .dll_met      (dll_met)
    );

    assign low     = st_is_low(st_q);
    assign go_exit = (st_q == PD_DOWN) && min_met && (wake_pend_q || wake_req || cap_hit);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PD_UP:    if (go_enter)   st_d = PD_ENTER;
            PD_ENTER: if (cpded_done) st_d = PD_DOWN;
            PD_DOWN:  if (go_exit)    st_d = PD_EXIT;
            PD_EXIT:  if (dll_met)    st_d = PD_UP;
            default:                  st_d = PD_UP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PD_UP;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_pend_q <= 1'b0;
        end else if (go_exit || !low) begin
            wake_pend_q <= 1'b0;
        end else if (wake_req) begin
            wake_pend_q <= 1'b1;
        end
    end

    assign cke            = !low;
    assign force_nop      = (st_q == PD_ENTER);
    assign grant_other    = (st_q == PD_UP) || (st_q == PD_EXIT && xp_met);
    assign grant_dll      = (st_q == PD_UP) || (st_q == PD_EXIT && dll_met);
    assign pd_active_mode = low && class_active;
    assign refresh_wake   = (st_q == PD_DOWN) && cap_hit;

    // R1: the falling clock-enable edge always carries a forced NOP
    assert_nop_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> force_nop);

    // R2: a blocking operation keeps the clock enable high
    assert_block_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PD_UP && (|busy_block)) |=> cke);

    // R5: no rise before the minimum low time
    assert_min_low_R5: assert property (@(posedge clk) disable iff (rst)
        (!cke && !min_met) |=> !cke);

    // R8: the forced wakeup is followed by the rise of the clock enable
    assert_refwake_rise_R8: assert property (@(posedge clk) disable iff (rst)
        refresh_wake |=> cke);

    // R9: reset always returns to the normal state
    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (cke && grant_other && grant_dll && !force_nop));

endmodule

// File: tb/pdn_seq_tb_top.sv
`timescale 1ns/1ps
module pdn_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_req = 1'b0;
    logic       wake_req = 1'b0;
    logic [4:0] busy_block = '0;
    logic [3:0] busy_allow = '0;
    logic [7:0] bank_open = '0;
    logic       exit_fast = 1'b0;
    logic [7:0] idle_cnt = '0;
    logic       cke, force_nop, grant_other, grant_dll, pd_active_mode, refresh_wake;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    always #2 clk = ~clk;

    pdn_seq dut_i (
        .clk            (clk),
        .rst            (rst),
        .pd_req         (pd_req),
        .wake_req       (wake_req),
        .busy_block     (busy_block),
        .busy_allow     (busy_allow),
        .bank_open      (bank_open),
        .exit_fast      (exit_fast),
        .idle_cnt       (idle_cnt),
        .cke            (cke),
        .force_nop      (force_nop),
        .grant_other    (grant_other),
        .grant_dll      (grant_dll),
        .pd_active_mode (pd_active_mode),
        .refresh_wake   (refresh_wake)
    );

    // expected bits: {cke, force_nop, grant_other, grant_dll, pd_active_mode, refresh_wake}
    typedef struct packed {
        logic       pd;
        logic       wk;
        logic [4:0] blk;
        logic [3:0] alw;
        logic [7:0] bnk;
        logic       fast;
        logic [7:0] idle;
        logic [2:0] reps;
        logic [3:0] req;
        logic [5:0] exp;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VT [NV] = '{
        // precharge power-down, slow exit: R2 hold, R1 entry, R5 delayed wake, R6/R7 grants
        '{1'b1,1'b0,5'h01,4'h0,8'h00,1'b0,8'd10,3'd1,4'd2, 6'b101100},
        '{1'b0,1'b0,5'h01,4'h0,8'h00,1'b0,8'd10,3'd2,4'd2, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd1, 6'b010000},
        '{1'b0,1'b1,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd5, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd1, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd5, 6'b000000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd5, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd2,4'd6, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd7,4'd7, 6'b101000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd6, 6'b101100},
        // active power-down, exit bit 0: R4 class, R7 fast exit regardless
        '{1'b1,1'b0,5'h00,4'h0,8'h04,1'b0,8'd10,3'd1,4'd4, 6'b010010},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd2,4'd4, 6'b010010},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd4, 6'b000010},
        '{1'b0,1'b1,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd5, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd2,4'd7, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100},
        // precharge power-down, exit bit 1 latched at entry: R7
        '{1'b1,1'b0,5'h00,4'h0,8'h00,1'b1,8'd10,3'd1,4'd1, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd2,4'd7, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b000000},
        '{1'b0,1'b1,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd2,4'd7, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100},
        // burst block then idle threshold: R2, R10, R5 late wake
        '{1'b1,1'b0,5'h10,4'h0,8'h00,1'b1,8'd10,3'd1,4'd2, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd3, 3'd2,4'd10,6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd1,4'd10,6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd2,4'd1, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd1,4'd1, 6'b000000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd3,4'd5, 6'b000000},
        '{1'b0,1'b1,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd1,4'd5, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd2,4'd6, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd1,4'd7, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b1,8'd4, 3'd1,4'd7, 6'b101100},
        // entry during precharge in flight, class settles to precharge: R3, R4
        '{1'b1,1'b0,5'h00,4'h2,8'h01,1'b0,8'd10,3'd1,4'd3, 6'b010010},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd4, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'hFF,1'b0,8'd10,3'd1,4'd4, 6'b010000},
        '{1'b0,1'b0,5'h00,4'h0,8'hFF,1'b0,8'd10,3'd1,4'd4, 6'b000000},
        '{1'b0,1'b1,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd5, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd2,4'd6, 6'b100000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd7,4'd7, 6'b101000},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100},
        '{1'b0,1'b0,5'h00,4'h0,8'h00,1'b0,8'd10,3'd1,4'd7, 6'b101100}
    };

    function automatic logic [5:0] outs();
        return {cke, force_nop, grant_other, grant_dll, pd_active_mode, refresh_wake};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int low_n, wake_n, wake_at;
        // R9: reset state
        step();
        step();
        check(outs() == 6'b101100, "R9 reset state", outs(), 6'b101100);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pd_req     = VT[i].pd;
            wake_req   = VT[i].wk;
            busy_block = VT[i].blk;
            busy_allow = VT[i].alw;
            bank_open  = VT[i].bnk;
            exit_fast  = VT[i].fast;
            idle_cnt   = VT[i].idle;
            for (int r = 0; r < int'(VT[i].reps); r++) begin
                step();
                check(outs() == VT[i].exp, $sformatf("R%0d vector %0d", VT[i].req, i),
                      outs(), VT[i].exp);
            end
        end

        // R8: refresh cap forces exit after 9*T_REFI = 72 low cycles
        pd_req = 1'b1; wake_req = 1'b0; busy_block = '0; busy_allow = '0;
        bank_open = '0; exit_fast = 1'b1; idle_cnt = 8'd10;
        step();
        pd_req = 1'b0;
        low_n = 0; wake_n = 0; wake_at = 0;
        for (int g = 0; g < 200; g++) begin
            if (cke) break;
            low_n++;
            if (refresh_wake) begin
                wake_n++;
                wake_at = low_n;
            end
            step();
        end
        check(low_n == 72, "R8 low length", low_n, 72);
        check(wake_n == 1, "R8 wake pulse count", wake_n, 1);
        check(wake_at == 72, "R8 wake pulse position", wake_at, 72);
        repeat (4) step();
        check(grant_other && grant_dll, "R6 grants after forced exit",
              {grant_other, grant_dll}, 2'b11);

        // R9: reset in the middle of power-down
        pd_req = 1'b1;
        step();
        pd_req = 1'b0;
        repeat (4) step();
        check(cke == 1'b0, "R1 low before reset", cke, 0);
        rst = 1'b1;
        step();
        check(outs() == 6'b101100, "R9 reset from power-down", outs(), 6'b101100);
        rst = 1'b0;

        // R9: a pending request is dropped by reset
        busy_block = 5'h04; pd_req = 1'b1;
        step();
        pd_req = 1'b0; rst = 1'b1;
        step();
        rst = 1'b0; busy_block = '0;
        repeat (3) step();
        check(cke == 1'b1, "R9 pending cleared by reset", cke, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule